// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading translation descriptors from memory. A request carries the virtual address, a process identifier and the first-level table base. When the virtual address lies in the lowest 32 MB, the walker folds the process identifier into the address at bit 25. This gives a modified address, so that processes with overlapping low addresses land on distinct table entries. All later indexing uses that modified address.

The walker fetches one first-level descriptor. Its two type bits select one of four outcomes: a fault, a 1 MB section that ends the walk, a coarse second-level table of 256 entries, or a fine second-level table of 1024 entries. For a table, the walker fetches one second-level descriptor. That descriptor selects a 64 KB, 4 KB or 1 KB page, or a fault. Descriptors come through a memory read port with one read outstanding. The walker reports each result as a one-cycle completion pulse carrying the physical address, a fault flag and the table level that faulted. Permission checks, domains, cache attributes and any translation caching sit outside this block.

Top module: `xw_walker`

## Requirements
- R1: The modified address equals the virtual address with the process identifier ORed in at bit 25 when virtual bits [31:25] are all zero. Otherwise it equals the virtual address unchanged.
- R2: The first read address is {tbl_base[31:14], modified[31:20], 2'b00}, and tbl_base[13:0] has no effect.
- R3: A first-level descriptor with bits [1:0]=00 completes the walk with done_fault=1, done_flvl=0 and done_pa=0, after exactly one read.
- R4: A first-level descriptor with bits [1:0]=10 is a section. It completes after one read with done_pa={desc[31:20], modified[19:0]}, done_fault=0 and done_flvl=0.
- R5: A first-level descriptor with bits [1:0]=01 selects a coarse table. The second read address is {desc[31:10], modified[19:12], 2'b00}.
- R6: A first-level descriptor with bits [1:0]=11 selects a fine table. The second read address is {desc[31:12], modified[19:10], 2'b00}.
- R7: A second-level descriptor with bits [1:0]=01 gives a 64 KB page, done_pa={desc[31:16], modified[15:0]}. This holds in both coarse and fine tables.
- R8: A second-level descriptor with bits [1:0]=10 gives a 4 KB page, done_pa={desc[31:12], modified[11:0]}. This holds in both coarse and fine tables.
- R9: A second-level descriptor with bits [1:0]=11 gives a 1 KB page, done_pa={desc[31:10], modified[9:0]}, but only in a fine table. In a coarse table, that type is a fault, and so is bits [1:0]=00 in either table kind. Each of these faults reports done_fault=1, done_flvl=1 and done_pa=0.
- R10: req_ready is high only while idle. A req_valid that arrives while a walk is in progress is ignored and starts no later walk.
- R11: mem_rd_req is a one-cycle pulse. The first read comes in the cycle after acceptance, and a second read comes only in the cycle after the first read's mem_rd_rvalid. A response must arrive no earlier than the cycle after its request.
- R12: done is a one-cycle pulse in the cycle after the final mem_rd_rvalid, and req_ready is high again in the following cycle.
- R13: A synchronous active-high rst returns the walker to idle: req_ready=1, mem_rd_req=0 and done=0 in the cycle after rst is sampled, even in the middle of a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_va | input | 32 | Virtual address to translate |
| req_pid | input | 7 | Process identifier for low-address remap |
| tbl_base | input | 32 | First-level table base (bits [31:14] used) |
| mem_rd_req | output | 1 | Descriptor read request pulse |
| mem_rd_addr | output | 32 | Descriptor read address |
| mem_rd_rvalid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Descriptor returned by memory |
| done | output | 1 | Walk complete pulse |
| done_pa | output | 32 | Translated physical address (zero on fault) |
| done_fault | output | 1 | Walk ended in a fault |
| done_flvl | output | 1 | Faulting level: 0 first, 1 second |

## Verification
The first read request is visible in the cycle after the request handshake. Each later read follows one cycle after the previous response, and the completion pulse follows one cycle after the last response. The bench plays the memory itself and drives and samples at the falling edge. From the request it sees, it knows the exact cycle in which each result must appear. It checks each read address on its pulse and the completion fields on the pulse. It also checks that nothing else happened in between, including the cycle after completion when the walker must be idle again. Response latency varies across scenarios, so that the one-cycle spacing holds whether memory answers at once or late.

// File: rtl/xw_pkg.sv
package xw_pkg;

   // walk sequencer states
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_L1_REQ  = 3'd1,
      ST_L1_WAIT = 3'd2,
      ST_L2_REQ  = 3'd3,
      ST_L2_WAIT = 3'd4,
      ST_DONE    = 3'd5
   } walk_st_e;

   // first-level type bits
   typedef enum logic [1:0] {
      L1_FAULT   = 2'b00,
      L1_COARSE  = 2'b01,
      L1_SECTION = 2'b10,
      L1_FINE    = 2'b11
   } l1_kind_e;

   // second-level type bits
   typedef enum logic [1:0] {
      L2_FAULT = 2'b00,
      L2_LARGE = 2'b01,
      L2_SMALL = 2'b10,
      L2_TINY  = 2'b11
   } l2_kind_e;

   localparam int unsigned DESC_W        = 32;
   localparam int unsigned TBL_ALIGN_LSB = 14;  // first-level table alignment
   localparam int unsigned SECT_LSB      = 20;  // 1 MB granule
   localparam int unsigned COARSE_LSB    = 10;  // coarse table base alignment
   localparam int unsigned FINE_LSB      = 12;  // fine table base alignment
   localparam int unsigned LARGE_LSB     = 16;  // 64 KB page
   localparam int unsigned SMALL_LSB     = 12;  // 4 KB page
   localparam int unsigned TINY_LSB      = 10;  // 1 KB page
   localparam int unsigned REMAP_LSB     = 25;  // 32 MB remap window

endpackage

// File: rtl/xw_mva_remap.sv
module xw_mva_remap #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned PID_W    = 7,
   parameter int unsigned WIN_LSB  = 25,
   parameter bit          REMAP_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] va,
   input  logic [PID_W-1:0]  pid,
   output logic [ADDR_W-1:0] mva
);

   localparam int unsigned HI_W = ADDR_W - WIN_LSB;

   generate
      if (WIN_LSB + PID_W > ADDR_W) begin : g_bad_pid
         $error("xw_mva_remap: PID_W does not fit above WIN_LSB");
      end
      if (WIN_LSB >= ADDR_W) begin : g_bad_win
         $error("xw_mva_remap: WIN_LSB must lie inside the address");
      end

      if (REMAP_EN) begin : g_remap
         logic             in_window;
         logic [ADDR_W-1:0] pid_field;
         assign in_window = (va[ADDR_W-1:WIN_LSB] == {HI_W{1'b0}});
         assign pid_field = {{(ADDR_W-PID_W){1'b0}}, pid} << WIN_LSB;
         assign mva       = in_window ? (va | pid_field) : va;
      end else begin : g_pass
         logic unused_pid;
         assign unused_pid = ^pid;
         assign mva        = va;
      end
   endgenerate

endmodule

// File: rtl/xw_l1_decode.sv
module xw_l1_decode
   import xw_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [DESC_W-1:0] desc,
   input  logic [ADDR_W-1:0] mva,
   output l1_kind_e          kind,
   output logic [ADDR_W-1:0] sect_pa,
   output logic [ADDR_W-1:0] l2_addr,
   output logic              l2_fine
);

   localparam int unsigned COARSE_IDX_W = SECT_LSB - SMALL_LSB;  // 8
   localparam int unsigned FINE_IDX_W   = SECT_LSB - TINY_LSB;   // 10

   generate
      if (ADDR_W != DESC_W) begin : g_bad_w
         $error("xw_l1_decode: address and descriptor widths must match");
      end
   endgenerate

   logic [ADDR_W-1:0] coarse_addr;
   logic [ADDR_W-1:0] fine_addr;

   assign kind    = l1_kind_e'(desc[1:0]);
   assign sect_pa = {desc[DESC_W-1:SECT_LSB], mva[SECT_LSB-1:0]};

   assign coarse_addr = {desc[DESC_W-1:COARSE_LSB],
                         mva[SECT_LSB-1 -: COARSE_IDX_W], 2'b00};
   assign fine_addr   = {desc[DESC_W-1:FINE_LSB],
                         mva[SECT_LSB-1 -: FINE_IDX_W], 2'b00};

   assign l2_fine = (kind == L1_FINE);
   assign l2_addr = l2_fine ? fine_addr : coarse_addr;

   logic unused_l1;
   assign unused_l1 = ^{mva[ADDR_W-1:SECT_LSB], desc[COARSE_LSB-1:2]};

endmodule

// File: rtl/xw_l2_decode.sv
module xw_l2_decode
   import xw_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [DESC_W-1:0] desc,
   input  logic [ADDR_W-1:0] mva,
   input  logic              in_fine,
   output logic              fault,
   output logic [ADDR_W-1:0] pa
);

   l2_kind_e kind;
   assign kind = l2_kind_e'(desc[1:0]);

   // one candidate address per page size, picked by a generate over sizes
   localparam int unsigned NSZ = 3;
   logic [ADDR_W-1:0] cand [NSZ];

   generate
      for (genvar g = 0; g < NSZ; g++) begin : g_size
         localparam int unsigned LSB = (g == 0) ? LARGE_LSB :
                                       (g == 1) ? SMALL_LSB : TINY_LSB;
         assign cand[g] = {desc[DESC_W-1:LSB], mva[LSB-1:0]};
      end
   endgenerate

   always_comb begin
      fault = 1'b0;
      pa    = '0;
      unique case (kind)
         L2_LARGE: pa = cand[0];
         L2_SMALL: pa = cand[1];
         L2_TINY: begin
            if (in_fine) pa = cand[2];
            else         fault = 1'b1;
         end
         default:  fault = 1'b1;
      endcase
   end

   logic unused_l2;
   assign unused_l2 = ^{mva[ADDR_W-1:LARGE_LSB], desc[TINY_LSB-1:2]};

endmodule

// File: rtl/xw_walker.sv
module xw_walker
   import xw_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned PID_W    = 7,
   parameter bit          REMAP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_va,
   input  logic [PID_W-1:0]  req_pid,
   input  logic [ADDR_W-1:0] tbl_base,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_rvalid,
   input  logic [DESC_W-1:0] mem_rd_data,
   output logic              done,
   output logic [ADDR_W-1:0] done_pa,
   output logic              done_fault,
   output logic              done_flvl
);

   localparam int unsigned L1_IDX_W = ADDR_W - SECT_LSB;

   generate
      if (ADDR_W != 32) begin : g_bad_addr
         $error("xw_walker: descriptor formats assume a 32-bit address");
      end
   endgenerate

   walk_st_e          state_q;
   logic [ADDR_W-1:0] mva_q;
   logic [ADDR_W-1:0] addr_q;
   logic              fine_q;
   logic [ADDR_W-1:0] pa_q;
   logic              fault_q;
   logic              flvl_q;

   logic [ADDR_W-1:0] mva_w;
   l1_kind_e          l1_kind;
   logic [ADDR_W-1:0] l1_sect_pa;
   logic [ADDR_W-1:0] l1_next_addr;
   logic              l1_fine;
   logic              l2_fault;
   logic [ADDR_W-1:0] l2_pa;
   logic [ADDR_W-1:0] l1_addr_w;

   xw_mva_remap #(
      .ADDR_W  (ADDR_W),
      .PID_W   (PID_W),
      .WIN_LSB (REMAP_LSB),
      .REMAP_EN(REMAP_EN)
   ) u_remap (
      .va (req_va),
      .pid(req_pid),
      .mva(mva_w)
   );

   xw_l1_decode #(.ADDR_W(ADDR_W)) u_l1 (
      .desc   (mem_rd_data),
      .mva    (mva_q),
      .kind   (l1_kind),
      .sect_pa(l1_sect_pa),
      .l2_addr(l1_next_addr),
      .l2_fine(l1_fine)
   );

   xw_l2_decode #(.ADDR_W(ADDR_W)) u_l2 (
      .desc   (mem_rd_data),
      .mva    (mva_q),
      .in_fine(fine_q),
      .fault  (l2_fault),
      .pa     (l2_pa)
   );

   assign l1_addr_w = {tbl_base[ADDR_W-1:TBL_ALIGN_LSB],
                       mva_w[ADDR_W-1 -: L1_IDX_W], 2'b00};

   logic unused_base;
   assign unused_base = ^tbl_base[TBL_ALIGN_LSB-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         mva_q   <= '0;
         addr_q  <= '0;
         fine_q  <= 1'b0;
         pa_q    <= '0;
         fault_q <= 1'b0;
         flvl_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  mva_q   <= mva_w;
                  addr_q  <= l1_addr_w;
                  state_q <= ST_L1_REQ;
               end
            end
            ST_L1_REQ:  state_q <= ST_L1_WAIT;
            ST_L1_WAIT: begin
               if (mem_rd_rvalid) begin
                  unique case (l1_kind)
                     L1_SECTION: begin
                        pa_q    <= l1_sect_pa;
                        fault_q <= 1'b0;
                        flvl_q  <= 1'b0;
                        state_q <= ST_DONE;
                     end
                     L1_COARSE, L1_FINE: begin
                        addr_q  <= l1_next_addr;
                        fine_q  <= l1_fine;
                        state_q <= ST_L2_REQ;
                     end
                     default: begin
                        pa_q    <= '0;
                        fault_q <= 1'b1;
                        flvl_q  <= 1'b0;
                        state_q <= ST_DONE;
                     end
                  endcase
               end
            end
            ST_L2_REQ:  state_q <= ST_L2_WAIT;
            ST_L2_WAIT: begin
               if (mem_rd_rvalid) begin
                  pa_q    <= l2_pa;
                  fault_q <= l2_fault;
                  flvl_q  <= 1'b1;
                  state_q <= ST_DONE;
               end
            end
            default:    state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready   = (state_q == ST_IDLE);
   assign mem_rd_req  = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
   assign mem_rd_addr = addr_q;
   assign done        = (state_q == ST_DONE);
   assign done_pa     = pa_q;
   assign done_fault  = fault_q;
   assign done_flvl   = flvl_q;

   AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      mem_rd_req |=> !mem_rd_req); // R11
   AST_ACCEPT_THEN_READ: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready) |=> mem_rd_req); // R11
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> (!mem_rd_req && !done)); // R10
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
      done |=> (!done && req_ready)); // R12
   AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (rst)
      (done && done_fault) |-> (done_pa == '0)); // R3
   AST_RESET_IDLE: assert property (@(posedge clk)
      rst |=> (req_ready && !mem_rd_req && !done)); // R13

endmodule

// File: tb/sim_xw_walker.sv
module sim_xw_walker;

   logic        clk = 1'b0;
   logic        rst;
   logic        req_valid;
   logic        req_ready;
   logic [31:0] req_va;
   logic [6:0]  req_pid;
   logic [31:0] tbl_base;
   logic        mem_rd_req;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_rvalid;
   logic [31:0] mem_rd_data;
   logic        done;
   logic [31:0] done_pa;
   logic        done_fault;
   logic        done_flvl;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;  // 125 MHz

   xw_walker u0 (
      .clk(clk), .rst(rst),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_va(req_va), .req_pid(req_pid), .tbl_base(tbl_base),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_rvalid(mem_rd_rvalid), .mem_rd_data(mem_rd_data),
      .done(done), .done_pa(done_pa), .done_fault(done_fault),
      .done_flvl(done_flvl)
   );

   task automatic chk(input bit ok, input string req,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One full walk; bench plays the memory. lat = extra response delay.
   task automatic walk(input string tag, input logic [31:0] va,
                       input logic [6:0] pid, input logic [31:0] base,
                       input logic [31:0] d1, input logic [31:0] d2,
                       input logic [31:0] a1, input logic [31:0] a2,
                       input int nrd, input logic [31:0] pa,
                       input bit flt, input bit lvl, input int lat,
                       input bit poke);
      int  nread   = 0;
      int  cnt     = -1;
      bit  rv_prev = 1'b0;
      bit  got     = 1'b0;
      int  busy_rdy = 0;
      @(negedge clk);
      req_valid = 1'b1; req_va = va; req_pid = pid; tbl_base = base;
      chk(req_ready == 1'b1, {tag, " R10 ready while idle"}, {31'd0, req_ready}, 32'd1);
      @(negedge clk);
      if (poke) begin
         req_va = 32'hFFFF_F000; req_pid = 7'h7F;
      end else begin
         req_valid = 1'b0;
      end
      chk(mem_rd_req == 1'b1, {tag, " R11 read cycle after accept"}, {31'd0, mem_rd_req}, 32'd1);
      for (int cyc = 0; cyc < 100 && !got; cyc++) begin
         if (cyc > 0) @(negedge clk);
         if (req_ready && !done) busy_rdy++;
         if (mem_rd_req) begin
            nread++;
            chk(cnt < 0, {tag, " R11 single outstanding"}, nread, 32'd1);
            if (nread == 1) chk(mem_rd_addr == a1, {tag, " R2 first read addr"}, mem_rd_addr, a1);
            else            chk(mem_rd_addr == a2, {tag, " R5/R6 second read addr"}, mem_rd_addr, a2);
            cnt = lat;
         end
         if (done) begin
            got = 1'b1;
            chk(rv_prev, {tag, " R12 done one cycle after response"}, {31'd0, rv_prev}, 32'd1);
            chk(done_fault == flt, {tag, " fault flag"}, {31'd0, done_fault}, {31'd0, flt});
            chk(done_flvl == lvl, {tag, " fault level"}, {31'd0, done_flvl}, {31'd0, lvl});
            chk(done_pa == pa, {tag, " physical address"}, done_pa, pa);
         end
         mem_rd_rvalid = 1'b0;
         rv_prev = 1'b0;
         if (!mem_rd_req && cnt == 0) begin
            mem_rd_rvalid = 1'b1;
            mem_rd_data   = (nread == 1) ? d1 : d2;
            rv_prev = 1'b1;
            cnt = -1;
         end else if (cnt > 0) begin
            cnt--;
         end
      end
      chk(got, {tag, " R12 done seen"}, {31'd0, got}, 32'd1);
      chk(nread == nrd, {tag, " R4/R11 read count"}, nread, nrd);
      chk(busy_rdy == 0, {tag, " R10 ready low while busy"}, busy_rdy, 32'd0);
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready && !done, {tag, " R12 idle after done"}, {30'd0, req_ready, done}, 32'd2);
      @(negedge clk);
      chk(!mem_rd_req && req_ready, {tag, " R10 busy request ignored"},
          {30'd0, mem_rd_req, req_ready}, 32'd1);
   endtask

   task automatic t_section_high();   // R4, R1 (no remap above window)
      walk("R4 section", 32'h8765_4321, 7'd5, 32'h3000_0000, 32'hABC0_0002, 32'h0,
           32'h3000_21D8, 32'h0, 1, 32'hABC5_4321, 1'b0, 1'b0, 0, 1'b0);
   endtask
   task automatic t_remap_low();      // R1, R2 with ignored base bits
      walk("R1 remap low", 32'h0012_3456, 7'd3, 32'h3000_0123, 32'h4560_0002, 32'h0,
           32'h3000_0184, 32'h0, 1, 32'h4562_3456, 1'b0, 1'b0, 2, 1'b0);
   endtask
   task automatic t_remap_edges();    // R1 window boundary both sides
      walk("R1 top of window", 32'h01FF_FFFF, 7'd1, 32'h3000_0000, 32'h1000_0002, 32'h0,
           32'h3000_00FC, 32'h0, 1, 32'h100F_FFFF, 1'b0, 1'b0, 1, 1'b0);
      walk("R1 above window", 32'h0200_0000, 7'd2, 32'h3000_0000, 32'h2000_0002, 32'h0,
           32'h3000_0080, 32'h0, 1, 32'h2000_0000, 1'b0, 1'b0, 0, 1'b0);
   endtask
   task automatic t_l1_fault();       // R3
      walk("R3 l1 fault", 32'h9000_0000, 7'd0, 32'h3000_0000, 32'h1234_5670, 32'h0,
           32'h3000_2400, 32'h0, 1, 32'h0, 1'b1, 1'b0, 3, 1'b0);
   endtask
   task automatic t_coarse();         // R5 R7 R8 R9
      walk("R7 coarse large", 32'h8012_3456, 7'd0, 32'h3000_0123, 32'h5555_5401, 32'hCAFE_0001,
           32'h3000_2004, 32'h5555_548C, 2, 32'hCAFE_3456, 1'b0, 1'b1, 0, 1'b0);
      walk("R8 coarse small", 32'h8012_3456, 7'd0, 32'h3000_0000, 32'h5555_5401, 32'hBEEF_1002,
           32'h3000_2004, 32'h5555_548C, 2, 32'hBEEF_1456, 1'b0, 1'b1, 2, 1'b0);
      walk("R9 coarse tiny fault", 32'h8012_3456, 7'd0, 32'h3000_0000, 32'h5555_5401, 32'hDEAD_BC03,
           32'h3000_2004, 32'h5555_548C, 2, 32'h0, 1'b1, 1'b1, 1, 1'b0);
      walk("R9 coarse l2 fault", 32'h8012_3456, 7'd0, 32'h3000_0000, 32'h5555_5401, 32'hFFFF_FFFC,
           32'h3000_2004, 32'h5555_548C, 2, 32'h0, 1'b1, 1'b1, 0, 1'b0);
   endtask
   task automatic t_fine();           // R6 R7 R8 R9
      walk("R9 fine tiny", 32'h8012_3456, 7'd0, 32'h3000_0000, 32'h6666_7003, 32'h7777_7C03,
           32'h3000_2004, 32'h6666_7234, 2, 32'h7777_7C56, 1'b0, 1'b1, 0, 1'b0);
      walk("R8 fine small", 32'h8012_3456, 7'd0, 32'h3000_0000, 32'h6666_7003, 32'h1234_5002,
           32'h3000_2004, 32'h6666_7234, 2, 32'h1234_5456, 1'b0, 1'b1, 3, 1'b0);
      walk("R7 fine large", 32'h8012_3456, 7'd0, 32'h3000_0000, 32'h6666_7003, 32'h9999_0001,
           32'h3000_2004, 32'h6666_7234, 2, 32'h9999_3456, 1'b0, 1'b1, 1, 1'b0);
   endtask
   task automatic t_busy_request();   // R10
      walk("R10 poke while busy", 32'h8012_3456, 7'd0, 32'h3000_0000, 32'h5555_5401, 32'hBEEF_1002,
           32'h3000_2004, 32'h5555_548C, 2, 32'hBEEF_1456, 1'b0, 1'b1, 2, 1'b1);
   endtask
   task automatic t_reset_midwalk();  // R13
      @(negedge clk);
      req_valid = 1'b1; req_va = 32'h8012_3456; req_pid = 7'd0; tbl_base = 32'h3000_0000;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(req_ready && !mem_rd_req && !done, "R13 reset mid-walk",
          {29'd0, req_ready, mem_rd_req, done}, 32'd4);
      @(negedge clk);
      chk(!mem_rd_req && !done, "R13 stays idle after reset",
          {30'd0, mem_rd_req, done}, 32'd0);
   endtask

   initial begin
      rst = 1'b1; req_valid = 1'b0; req_va = '0; req_pid = '0; tbl_base = '0;
      mem_rd_rvalid = 1'b0; mem_rd_data = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk(req_ready && !mem_rd_req && !done, "R13 reset state",
          {29'd0, req_ready, mem_rd_req, done}, 32'd4);
      t_section_high();
      t_remap_low();
      t_remap_edges();
      t_l1_fault();
      t_coarse();
      t_fine();
      t_busy_request();
      t_reset_midwalk();
      t_section_high();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
         $finish;
      end
   end

endmodule